// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block takes interrupt requests from a set of external sources and spreads them over several target contexts. A context is one privilege mode of one hardware thread. Every source passes through its own gateway. The gateway turns an edge or a level into a single pending request and holds back further requests from that source while a handler owns it. Each context has its own mask of enabled sources and its own priority threshold. A per-context arbiter picks the best pending source, and a registered interrupt line tells the context that work is waiting.

Software talks to the block through a single-cycle register port. A read of a context's claim word returns the winning source ID (0 when nothing qualifies) and takes that source out of pending in the same cycle. Writing the same ID back to that word completes the handler and reopens the source's gateway. Sources are numbered 1 to NSRC; ID 0 is reserved. Source ID s is wired to input bit `src_i[s-1]`.

Register map (8-bit address; page in bits 7:4, index in bits 3:0): page 0 index s = priority of source s; page 1 index 0 = pending bits (read-only), page 1 index 1 = trigger mode bits (1 = edge); page 2 index c = enable mask of context c; page 3 index c = threshold of context c; page 4 index c = claim (read) / complete (write) of context c. In every bit array, bit s stands for source s and bit 0 reads as 0.

Top module: `plic_core`

## Requirements
- R1: After reset all interrupt lines are low, the pending word (0x10) reads 0, every claim word reads 0, and all sources are level-triggered.
- R2: A level-triggered source whose input is high becomes pending at the next clock edge, and bit s of the pending word (0x10) shows source s.
- R3: A source whose mode bit (0x11, bit s) is 1 latches a rising input edge into pending. Edges that arrive while the source is pending or claimed are dropped, so at most one request per source is outstanding.
- R4: A claim read of context c (0x40+c) returns only a source whose bit is set in that context's enable mask (0x20+c).
- R5: A claim read returns the pending enabled source with the highest non-zero priority, and the lower ID when priorities are equal. A source with priority 0 is never returned.
- R6: The line of context c is high only when the best pending enabled priority is non-zero and at least that context's threshold (0x30+c). The threshold does not gate claims.
- R7: Each interrupt line is registered. It reflects the pending, enable, priority and threshold state one clock edge later.
- R8: A claim read that returns a non-zero ID clears that source's pending bit at the same clock edge. A claim read with nothing qualifying returns 0 and changes nothing.
- R9: A claimed source stays out of pending until its ID is written to a claim word. A write of an ID that is not claimed is ignored. A level source still high after completion becomes pending again one edge later.
- R10: Priority words read back the written value in their low PW bits. Writes to the pending word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt request inputs; bit s-1 is source s |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect only on claim words) |
| addr_i | input | 8 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid in the cycle of the read |
| irq_o | output | NCTX | Registered interrupt line per context |

## Verification
A gateway stuck in the wrong state shows up at the pending word within one cycle. A source that was never released, or one released too early, shows up in the claim ID and the pending bit that follow the next completion. An arbiter that ranks sources wrongly returns the wrong ID on the very claim read that exposes it. A wrong threshold compare shows up on the interrupt line one edge after the state settles. The sweep runs through 128 combinations of pending sets, priorities with ties and zeros, enable masks and thresholds, so each of these faults reaches a port within a few cycles of its cause.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;

    localparam logic [3:0] PG_PRIO  = 4'h0;
    localparam logic [3:0] PG_STAT  = 4'h1;
    localparam logic [3:0] PG_EN    = 4'h2;
    localparam logic [3:0] PG_THR   = 4'h3;
    localparam logic [3:0] PG_CLAIM = 4'h4;

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o,
    output logic busy_o
);

    gw_state_e state_q, state_d;
    logic      req_q;
    logic      fire;

    assign fire = edge_mode_i ? (req_i & ~req_q) : req_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (fire)       state_d = GW_PEND;
            GW_PEND: if (claim_i)    state_d = GW_BUSY;
            GW_BUSY: if (complete_i) state_d = GW_IDLE;
            default:                 state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending_o = (state_q == GW_PEND);
        busy_o    = (state_q == GW_BUSY);
    end

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NSRC = 7,
    parameter int PW   = 3,
    localparam int IDW = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]      pend_i,
    input  logic [NSRC:1]      en_i,
    input  logic [NSRC*PW-1:0] prio_i,
    output logic [IDW-1:0]     id_o,
    output logic [PW-1:0]      prio_o
);

    always_comb begin
        id_o   = '0;
        prio_o = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (pend_i[s] && en_i[s] && (prio_i[(s-1)*PW +: PW] > prio_o)) begin
                prio_o = prio_i[(s-1)*PW +: PW];
                id_o   = IDW'(s);
            end
        end
    end

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int NSRC = 7,
    parameter int NCTX = 2,
    parameter int PW   = 3,
    parameter int DW   = 32,
    localparam int IDW = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic [NCTX-1:0]   irq_o
);

    logic [3:0]         pg;
    int                 idx_n;
    logic [NSRC*PW-1:0] prio_q;
    logic [NSRC:1]      edge_q;
    logic [NSRC:1]      en_q  [NCTX];
    logic [PW-1:0]      thr_q [NCTX];
    logic [NSRC:1]      pend_vec, busy_vec, claim_vec, comp_vec;
    logic [IDW-1:0]     win_id [NCTX];
    logic [PW-1:0]      win_pr [NCTX];
    logic               wr_claim;

    assign pg       = addr_i[ADDR_W-1:ADDR_W-4];
    assign idx_n    = int'(addr_i[3:0]);
    assign wr_claim = wr_en_i && (pg == PG_CLAIM) && (idx_n < NCTX);

    for (genvar s = 1; s <= NSRC; s++) begin : g_gw
        plic_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (src_i[s-1]),
            .edge_mode_i(edge_q[s]),
            .claim_i    (claim_vec[s]),
            .complete_i (comp_vec[s]),
            .pending_o  (pend_vec[s]),
            .busy_o     (busy_vec[s])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        plic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
            .pend_i(pend_vec),
            .en_i  (en_q[c]),
            .prio_i(prio_q),
            .id_o  (win_id[c]),
            .prio_o(win_pr[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) irq_o[c] <= 1'b0;
            else        irq_o[c] <= (win_pr[c] != '0) && (win_pr[c] >= thr_q[c]);
        end
    end

    // claim pulses from a claim read, completion pulses from a claim-word write
    always_comb begin
        claim_vec = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (rd_en_i && (pg == PG_CLAIM) && (idx_n == c) && (win_id[c] != '0))
                claim_vec[win_id[c]] = 1'b1;
        end
        for (int s = 1; s <= NSRC; s++)
            comp_vec[s] = wr_claim && (wdata_i == DW'(s)) && busy_vec[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            edge_q <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (wr_en_i) begin
            case (pg)
                PG_PRIO: for (int s = 1; s <= NSRC; s++)
                    if (idx_n == s) prio_q[(s-1)*PW +: PW] <= wdata_i[PW-1:0];
                PG_STAT: if (idx_n == 1) edge_q <= wdata_i[NSRC:1];
                PG_EN: for (int c = 0; c < NCTX; c++)
                    if (idx_n == c) en_q[c] <= wdata_i[NSRC:1];
                PG_THR: for (int c = 0; c < NCTX; c++)
                    if (idx_n == c) thr_q[c] <= wdata_i[PW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (pg)
            PG_PRIO: for (int s = 1; s <= NSRC; s++)
                if (idx_n == s) rdata_o[PW-1:0] = prio_q[(s-1)*PW +: PW];
            PG_STAT: begin
                if (idx_n == 0) rdata_o[NSRC:1] = pend_vec;
                if (idx_n == 1) rdata_o[NSRC:1] = edge_q;
            end
            PG_EN: for (int c = 0; c < NCTX; c++)
                if (idx_n == c) rdata_o[NSRC:1] = en_q[c];
            PG_THR: for (int c = 0; c < NCTX; c++)
                if (idx_n == c) rdata_o[PW-1:0] = thr_q[c];
            PG_CLAIM: for (int c = 0; c < NCTX; c++)
                if (idx_n == c) rdata_o[IDW-1:0] = win_id[c];
            default: ;
        endcase
    end

endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk
    import plic_pkg::*;
#(
    parameter int NSRC = 7,
    parameter int NCTX = 2,
    parameter int DW   = 32,
    localparam int IDW = $clog2(NSRC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     rdata,
    input logic [NCTX-1:0]   irq,
    input logic [NSRC:1]     pend,
    input logic [NSRC:1]     busy,
    input logic [NSRC:1]     en [NCTX]
);

    logic           last_claim;
    logic [IDW-1:0] last_id;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_claim <= 1'b0;
            last_id    <= '0;
        end else begin
            last_claim <= rd_en && (addr[ADDR_W-1:ADDR_W-4] == PG_CLAIM)
                          && (int'(addr[3:0]) < NCTX) && (rdata[IDW-1:0] != '0);
            last_id    <= rdata[IDW-1:0];
        end
    end

    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        last_claim |-> (busy[last_id] && !pend[last_id])); // R8

    for (genvar c = 0; c < NCTX; c++) begin : g_c
        logic claim_rd;
        assign claim_rd = rd_en && (addr == {PG_CLAIM, 4'(c)});

        AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_rd && ((pend & en[c]) == '0)) |-> (rdata == '0)); // R8

        AST_CLAIM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_rd && (rdata != '0)) |-> (pend[rdata[IDW-1:0]] && en[c][rdata[IDW-1:0]])); // R4

        AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> $past((pend & en[c]) != '0)); // R7
    end

    for (genvar s = 1; s <= NSRC; s++) begin : g_s
        AST_NO_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            busy[s] |=> !pend[s]); // R9
    end

endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NCTX(NCTX), .DW(DW)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(rd_en_i),
    .addr (addr_i),
    .rdata(rdata_o),
    .irq  (irq_o),
    .pend (pend_vec),
    .busy (busy_vec),
    .en   (en_q)
);

// File: tb/tb_plic_core.sv
`timescale 1ns/1ps
module tb_plic_core;

    localparam int NSRC = 7;
    localparam int NCTX = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            wr_en_i = 1'b0;
    logic            rd_en_i = 1'b0;
    logic [7:0]      addr_i = '0;
    logic [31:0]     wdata_i = '0;
    logic [31:0]     rdata_o;
    logic [NCTX-1:0] irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    int         prio [8];
    logic [7:0] en   [2];
    int         thr  [2];

    always #2 clk = ~clk;

    plic_core dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        #1 d = int'(rdata_o);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    function automatic int best_id(input int c, input logic [7:0] p);
        int id = 0, bp = 0;
        for (int s = 1; s <= NSRC; s++)
            if (p[s] && en[c][s] && prio[s] > bp) begin bp = prio[s]; id = s; end
        return id;
    endfunction

    function automatic int exp_irq(input int c, input logic [7:0] p);
        int id = best_id(c, p);
        if (id == 0) return 0;
        return (prio[id] >= thr[c]) ? 1 : 0;
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int d, id0, id1;
        logic [7:0] pat, p2, p3;

        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1 irq after reset", int'(irq_o), 0);
        rd(8'h10, d); check("R1 pending after reset", d, 0);
        rd(8'h40, d); check("R1 claim ctx0 after reset", d, 0);
        rd(8'h41, d); check("R1 claim ctx1 after reset", d, 0);
        rd(8'h11, d); check("R1 mode after reset", d, 0);

        // R10 register readback, pending is read-only
        wr(8'h03, 5); rd(8'h03, d); check("R10 priority readback", d, 5);
        wr(8'h10, 32'hFE); rd(8'h10, d); check("R10 pending write ignored", d, 0);

        // sweep over level-source patterns, priorities, masks, thresholds
        for (int t = 0; t < 128; t++) begin
            do_reset();
            for (int s = 1; s <= NSRC; s++) begin
                prio[s] = (s * t + (t >> 3)) % 8;
                wr(8'(s), prio[s]);
            end
            en[0] = 8'((t * 37 + 11)) & 8'hFE;
            en[1] = (8'(t * 91) ^ 8'hAA) & 8'hFE;
            thr[0] = t % 8;
            thr[1] = (t * 3) % 8;
            wr(8'h20, int'(en[0])); wr(8'h21, int'(en[1]));
            wr(8'h30, thr[0]);      wr(8'h31, thr[1]);
            pat = {t[6:0], 1'b0};
            @(negedge clk);
            src_i = pat[7:1];
            @(negedge clk);
            rd(8'h10, d); check("R2 level pending", d, int'(pat));
            check("R6 irq ctx0", int'(irq_o[0]), exp_irq(0, pat));
            check("R6 irq ctx1", int'(irq_o[1]), exp_irq(1, pat));

            rd(8'h40, id0); check("R5 claim ctx0", id0, best_id(0, pat));
            p2 = pat;
            if (id0 != 0) p2[id0] = 1'b0;
            rd(8'h10, d); check("R8 claim clears pending", d, int'(p2));
            rd(8'h41, id1); check("R4 claim ctx1", id1, best_id(1, p2));
            p3 = p2;
            if (id1 != 0) p3[id1] = 1'b0;
            @(negedge clk);
            check("R7 irq ctx0 after claims", int'(irq_o[0]), exp_irq(0, p3));
            check("R7 irq ctx1 after claims", int'(irq_o[1]), exp_irq(1, p3));

            if (id0 != 0) wr(8'h40, id0);
            if (id1 != 0) wr(8'h41, id1);
            @(negedge clk);
            rd(8'h10, d); check("R9 level re-pends after completion", d, int'(pat));
        end

        // R3 edge sources and R9 blocking until completion
        do_reset();
        for (int s = 0; s < 8; s++) prio[s] = 0;
        prio[1] = 2;
        en[0] = 8'hFE;
        wr(8'h01, 2); wr(8'h20, 32'hFE); wr(8'h11, 32'hFE);
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); src_i[0] = 1'b0;
        rd(8'h10, d); check("R3 edge latched", d, 2);
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); src_i[0] = 1'b0;
        rd(8'h10, d); check("R3 second edge while pending", d, 2);
        rd(8'h40, d); check("R3 claim edge source", d, 1);
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); src_i[0] = 1'b0;
        rd(8'h10, d); check("R3 edge while claimed dropped", d, 0);
        wr(8'h40, 5);
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); src_i[0] = 1'b0;
        rd(8'h10, d); check("R9 wrong completion ignored", d, 0);
        wr(8'h40, 1);
        @(negedge clk);
        rd(8'h10, d); check("R3 no pending after completion", d, 0);
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); src_i[0] = 1'b0;
        rd(8'h10, d); check("R3 new edge after completion", d, 2);
        @(negedge clk);
        check("R6 threshold 0 edge irq", int'(irq_o[0]), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule